// File: doc/BRIEF.md
# Extended Address and Chip-Select Unit

This block owns the four upper external address pins of an 8-bit microcontroller and the registers that steer them. A control register decides what the pins mean. In extended-address mode they carry a 4-bit bank number that becomes address bits 19:16. The bank appears only for table reads from program memory and for external data moves, so instruction fetches stay inside the first 64 KB. In chip-select mode the pins become four active-low selects. Address bits 15:14 decode them, so each select covers one 16 KB window.

A page register supplies the high address byte for paged, register-indirect data moves. The low byte of those moves comes from the core's indirect pointer. Every other cycle type uses the core's 16-bit address as it is. The core marks the address phase of each bus cycle with a one-cycle strobe and a cycle-kind code. The block registers both the 16-bit external address and the four upper pins on that strobe. Its outputs therefore change only at cycle boundaries, and a register write never alters a cycle already under way.

The special-function-register port reads and writes the two registers. Reads at any other address are reported as not selected and return zero.

Top module: `ext_addr_unit`

## Requirements
- R1: After reset the control register reads 70h, the page register reads 00h, and both the upper pins and the external address are 0.
- R2: The control register is at SFR address A2h. Bit 7 is the mode (0 extended address, 1 chip select) and bits 3:0 are the bank. Bits 6:4 always read 111, whatever was written.
- R3: The page register is at SFR address A1h and reads back the full 8-bit value last written.
- R4: A read at any SFR address other than A1h or A2h returns data 00h with the select flag low. A write to such an address changes neither register.
- R5: In extended-address mode, a cycle of kind table read (01), pointer data move (10) or paged data move (11) drives the upper pins with the bank field.
- R6: In extended-address mode, an instruction fetch (kind 00) drives the upper pins to 0000.
- R7: In chip-select mode, for every cycle kind, exactly one upper pin is low: the pin whose index equals external address bits 15:14.
- R8: For a paged data move the external address is {page register, indirect low byte}. For every other kind it is the core's 16-bit address.
- R9: Both outputs are registered on the address-phase strobe. They show the new cycle's values from the clock edge that samples the strobe and hold them until the next strobe.
- R10: A register write in the same clock as a strobe does not affect that cycle's outputs. It takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write enable |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rd_i | input | 1 | SFR read enable |
| sfr_rdata_o | output | 8 | SFR read data, 00h when not selected |
| sfr_sel_o | output | 1 | Read hit one of this block's registers |
| cyc_start_i | input | 1 | Address-phase strobe of a bus cycle |
| cyc_kind_i | input | 2 | 00 fetch, 01 table read, 10 pointer data move, 11 paged data move |
| core_addr_i | input | 16 | Core address (program counter or data pointer) |
| ind_lo_i | input | 8 | Indirect pointer low byte |
| ext_addr_o | output | 16 | Registered external address |
| upper_o | output | 4 | Bank bits 19:16 or active-low chip selects |

## Verification
On every cycle the assertions check three things. In chip-select mode exactly one select is low and its index matches the registered address. Fetches in extended-address mode leave the pins at zero. Outputs never move without a strobe. The reserved control bits and the zero data on unselected reads are also checked continuously. Only the bench scenarios can show the rest: that writes reach the right register, that an unmapped write leaves both registers untouched, that paged moves build the address from the page register, and that a write coinciding with a strobe is deferred by exactly one bus cycle.

// File: rtl/xa_pkg.sv
package xa_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_TABLE = 2'b01,
    CYC_DATA  = 2'b10,
    CYC_PAGED = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/xa_sfr_regs.sv
module xa_sfr_regs #(
  parameter int          DATA_W    = 8,
  parameter int          BANK_W    = 4,
  parameter logic [7:0]  CTRL_ADDR = 8'hA2,
  parameter logic [7:0]  PAGE_ADDR = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic              mode_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] page_o
);
  localparam int RSV_W = DATA_W - 1 - BANK_W;

  logic              mode_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] page_q;
  logic              hit_ctrl, hit_page;

  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign hit_page = (addr_i == PAGE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      bank_q <= '0;
      page_q <= '0;
    end else if (wr_i) begin
      if (hit_ctrl) begin
        mode_q <= wdata_i[DATA_W-1];
        bank_q <= wdata_i[BANK_W-1:0];
      end
      if (hit_page) page_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    sel_o   = 1'b0;
    if (rd_i && hit_ctrl) begin
      rdata_o = {mode_q, {RSV_W{1'b1}}, bank_q};
      sel_o   = 1'b1;
    end else if (rd_i && hit_page) begin
      rdata_o = page_q;
      sel_o   = 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign bank_o = bank_q;
  assign page_o = page_q;

  // R2
  rsv_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_ctrl) |-> (rdata_o[DATA_W-2 -: RSV_W] == {RSV_W{1'b1}}));
  // R4
  unsel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> (rdata_o == '0));
endmodule

// File: rtl/xa_cs_decode.sv
module xa_cs_decode #(
  parameter int PIN_W = 4,
  localparam int SEL_W = $clog2(PIN_W)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [PIN_W-1:0] cs_n_o
);
  for (genvar g = 0; g < PIN_W; g++) begin : g_cs
    assign cs_n_o[g] = (sel_i != SEL_W'(g));
  end
endmodule

// File: rtl/xa_bus_latch.sv
module xa_bus_latch
  import xa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PIN_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cyc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [ADDR_W-PAGE_W-1:0] ind_lo_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              mode_i,
  input  logic [PIN_W-1:0]  bank_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PIN_W-1:0]  upper_o
);
  localparam int SEL_W = $clog2(PIN_W);

  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [PIN_W-1:0]  cs_n, upper_d, upper_q;
  logic              mode_cyc_q;
  cyc_kind_e         kind_q;

  assign addr_d = (kind_i == CYC_PAGED) ? {page_i, ind_lo_i} : core_addr_i;

  xa_cs_decode #(.PIN_W(PIN_W)) u_dec (
    .sel_i  (addr_d[ADDR_W-1 -: SEL_W]),
    .cs_n_o (cs_n)
  );

  always_comb begin
    if (mode_i)                  upper_d = cs_n;
    else if (kind_i == CYC_FETCH) upper_d = '0;
    else                         upper_d = bank_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      upper_q    <= '0;
      mode_cyc_q <= 1'b0;
      kind_q     <= CYC_FETCH;
    end else if (start_i) begin
      addr_q     <= addr_d;
      upper_q    <= upper_d;
      mode_cyc_q <= mode_i;
      kind_q     <= kind_i;
    end
  end

  assign addr_o  = addr_q;
  assign upper_o = upper_q;

  // R7
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_cyc_q |-> (($countones(~upper_q) == 1) && !upper_q[addr_q[ADDR_W-1 -: SEL_W]]));
  // R6
  fetch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_cyc_q && kind_q == CYC_FETCH) |-> (upper_q == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(upper_q) && $stable(addr_q)));
endmodule

// File: rtl/ext_addr_unit.sv
module ext_addr_unit
  import xa_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         PIN_W     = 4,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CTRL_ADDR = 8'hA2,
  parameter logic [7:0] PAGE_ADDR = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  input  logic              sfr_rd_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  output logic              sfr_sel_o,
  input  logic              cyc_start_i,
  input  logic [1:0]        cyc_kind_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [ADDR_W-DATA_W-1:0] ind_lo_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [PIN_W-1:0]  upper_o
);
  logic              mode;
  logic [PIN_W-1:0]  bank;
  logic [DATA_W-1:0] page;

  xa_sfr_regs #(
    .DATA_W(DATA_W), .BANK_W(PIN_W),
    .CTRL_ADDR(CTRL_ADDR), .PAGE_ADDR(PAGE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(sfr_addr_i), .wr_i(sfr_wr_i), .wdata_i(sfr_wdata_i),
    .rd_i(sfr_rd_i), .rdata_o(sfr_rdata_o), .sel_o(sfr_sel_o),
    .mode_o(mode), .bank_o(bank), .page_o(page)
  );

  xa_bus_latch #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .PAGE_W(DATA_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(cyc_start_i), .kind_i(cyc_kind_e'(cyc_kind_i)),
    .core_addr_i(core_addr_i), .ind_lo_i(ind_lo_i),
    .page_i(page), .mode_i(mode), .bank_i(bank),
    .addr_o(ext_addr_o), .upper_o(upper_o)
  );
endmodule

// File: tb/ext_addr_unit_bench.sv
module ext_addr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata, ind_lo = '0;
  logic        sfr_wr = 1'b0, sfr_rd = 1'b0, sfr_sel, cyc_start = 1'b0;
  logic [1:0]  cyc_kind = '0;
  logic [15:0] core_addr = '0, ext_addr;
  logic [3:0]  upper;

  int checks = 0, fails = 0;
  bit done = 0;

  logic       m_mode = 0;
  logic [3:0] m_bank = 0;
  logic [7:0] m_page = 0;
  logic [15:0] e_addr = 0;
  logic [3:0]  e_upper = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_addr_unit u_ext_addr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_addr_i(sfr_addr), .sfr_wr_i(sfr_wr), .sfr_wdata_i(sfr_wdata),
    .sfr_rd_i(sfr_rd), .sfr_rdata_o(sfr_rdata), .sfr_sel_o(sfr_sel),
    .cyc_start_i(cyc_start), .cyc_kind_i(cyc_kind),
    .core_addr_i(core_addr), .ind_lo_i(ind_lo),
    .ext_addr_o(ext_addr), .upper_o(upper)
  );

  function automatic logic [15:0] f_addr(logic [1:0] k, logic [15:0] a, logic [7:0] lo, logic [7:0] pg);
    return (k == 2'b11) ? {pg, lo} : a;
  endfunction

  function automatic logic [3:0] f_upper(logic md, logic [3:0] bk, logic [1:0] k, logic [15:0] ea);
    if (md) return ~(4'b0001 << ea[15:14]);
    if (k == 2'b00) return 4'b0000;
    return bk;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, {16'h0, ext_addr}, {16'h0, e_addr});
    chk(req, {28'h0, upper}, {28'h0, e_upper});
  endtask

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(posedge clk);
    if (a == 8'hA2) begin m_mode = d[7]; m_bank = d[3:0]; end
    if (a == 8'hA1) m_page = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(logic [7:0] a, string req);
    logic [7:0] exp;
    logic       hit;
    sfr_addr = a; sfr_rd = 1'b1;
    #1;
    hit = (a == 8'hA1) || (a == 8'hA2);
    exp = (a == 8'hA2) ? {m_mode, 3'b111, m_bank} : (a == 8'hA1) ? m_page : 8'h00;
    chk(req, {24'h0, sfr_rdata}, {24'h0, exp});
    chk(req, {31'h0, sfr_sel}, {31'h0, hit});
    sfr_rd = 1'b0;
  endtask

  task automatic bus_cycle(logic [1:0] k, logic [15:0] a, logic [7:0] lo, string req);
    cyc_kind = k; core_addr = a; ind_lo = lo; cyc_start = 1'b1;
    e_addr  = f_addr(k, a, lo, m_page);
    e_upper = f_upper(m_mode, m_bank, k, e_addr);
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    chk_out(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0c38);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {16'h0, ext_addr}, 32'h0);
    chk("R1", {28'h0, upper}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    sfr_read(8'hA2, "R1");
    sfr_read(8'hA1, "R1");

    // R2 reserved bits, R3 page
    sfr_write(8'hA2, 8'h05); sfr_read(8'hA2, "R2");
    sfr_write(8'hA1, 8'h5A); sfr_read(8'hA1, "R3");
    // R4 unmapped read and write
    sfr_write(8'hA3, 8'hFF); sfr_write(8'hA0, 8'h81);
    sfr_read(8'hA2, "R4"); sfr_read(8'hA1, "R4"); sfr_read(8'hC0, "R4");

    // R5 / R6 extended mode
    bus_cycle(2'b00, 16'hFFFF, 8'h00, "R6");
    bus_cycle(2'b01, 16'h1234, 8'h00, "R5");
    bus_cycle(2'b10, 16'h8001, 8'h00, "R5");
    // R8 paged move
    bus_cycle(2'b11, 16'hBEEF, 8'h3C, "R8");
    // R9 hold without strobe
    core_addr = 16'hC000; cyc_kind = 2'b01;
    repeat (3) @(negedge clk);
    chk_out("R9");

    // R7 chip-select mode, window boundaries
    sfr_write(8'hA2, 8'h80);
    bus_cycle(2'b00, 16'h3FFF, 8'h00, "R7");
    bus_cycle(2'b01, 16'h4000, 8'h00, "R7");
    bus_cycle(2'b10, 16'hBFFF, 8'h00, "R7");
    sfr_write(8'hA1, 8'hC7);
    bus_cycle(2'b11, 16'h0000, 8'h10, "R7");

    // R10 write coinciding with strobe
    cyc_kind = 2'b01; core_addr = 16'h2000; ind_lo = 0; cyc_start = 1'b1;
    sfr_addr = 8'hA2; sfr_wdata = 8'h09; sfr_wr = 1'b1;
    e_addr = 16'h2000; e_upper = f_upper(m_mode, m_bank, 2'b01, 16'h2000);
    @(posedge clk);
    m_mode = 1'b0; m_bank = 4'h9;
    @(negedge clk);
    cyc_start = 1'b0; sfr_wr = 1'b0;
    chk_out("R10");
    bus_cycle(2'b01, 16'h2000, 8'h00, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: sfr_write(8'hA2, 8'($urandom));
        1: sfr_write(8'hA1, 8'($urandom));
        2: sfr_read(($urandom_range(0, 1) != 0) ? 8'hA2 : 8'($urandom), "R4");
        default: begin
          logic [1:0] k;
          k = 2'($urandom);
          bus_cycle(k, 16'($urandom), 8'($urandom), m_mode ? "R7" : (k == 2'b00 ? "R6" : "R5"));
        end
      endcase
      chk_out("R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule